// File: doc/BRIEF.md
# Two-Bit Majority Carry Adder

This block adds two unsigned operands of an even, parameterised width and returns the sum together with a carry-out. Every carry is formed with three-input majority functions and inverters only. Each bit position produces an OR term and an AND term. A carry then moves forward two bit positions per slice, through a single outer majority whose two inner inputs come from those per-bit terms. The carry into the least significant position is fixed at zero, so the lowest slice uses a reduced form.

The adder is used as a plain combinational datapath element. A build parameter can add one output register, which is useful when the adder has to be timed between flops. Sum bits are also formed by majority and inversion. An odd width is refused when the design is elaborated.

Top module: `maj_pair_adder`

## Requirements
- R1: With carry-in fixed at 0, `{carry_out, sum}` equals the (WIDTH+1)-bit unsigned value `op_a + op_b` for every pair of operands.
- R2: The carry entering each even bit position 2k+2 equals the lookahead value g(2k+1) | p(2k+1)&g(2k) | p(2k+1)&p(2k)&c(2k), where p = a|b and g = a&b. At the ports, carry_out is 1 whenever both most significant operand bits are 1.
- R3: A carry generated at bit 0 propagates across the whole width: all-ones + 1 gives sum 0 with carry_out 1, and all-ones + all-ones gives sum all-ones minus 1 with carry_out 1.
- R4: Operands with no generate term produce no carry: 0 + 0 gives 0 with carry_out 0, and alternating 0101... + 1010... gives all ones with carry_out 0.
- R5: The same results hold for WIDTH values of 8, 16, 32 and 64.
- R6: With REG_OUT = 0 the outputs follow the operands with no clock edge.
- R7: With REG_OUT = 1 the outputs present the result of the operands sampled at the previous rising clock edge and keep that value until the next edge.
- R8: With REG_OUT = 1 a synchronous active-high `rst` clears sum and carry_out to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the property checks |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH | Low WIDTH bits of the result |
| carry_out | output | 1 | Carry out of the most significant slice |

## Verification
The bench builds four combinational copies with WIDTH of 8, 16, 32 and 64, and one registered copy with WIDTH 16. The 8-bit copy makes an exhaustive sweep of all operand pairs practical, so every carry pattern through four slices is visited. The wider copies receive all-ones, all-zeros, alternating and random patterns, which reach carry chains that cross 32 slices. The registered copy exposes the one-edge latency and the reset clear.

// File: rtl/maj_add_pkg.sv
package maj_add_pkg;

    typedef struct packed {
        logic prop;
        logic gen;
    } bit_terms_t;

    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // Three-input parity built only from majority and inversion.
    function automatic logic maj_parity(input logic x, input logic y, input logic z);
        return maj3(~maj3(x, y, z), maj3(x, y, ~z), z);
    endfunction

endpackage

// File: rtl/maj_bit_terms.sv
module maj_bit_terms
    import maj_add_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output bit_terms_t [WIDTH-1:0] terms
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign terms[i].prop = op_a[i] | op_b[i];
        assign terms[i].gen  = op_a[i] & op_b[i];
    end
endmodule

// File: rtl/maj_sum_cell.sv
module maj_sum_cell
    import maj_add_pkg::*;
(
    input  logic bit_a,
    input  logic bit_b,
    input  logic carry_in,
    output logic sum_bit
);
    assign sum_bit = maj_parity(bit_a, bit_b, carry_in);
endmodule

// File: rtl/maj_pair_slice.sv
module maj_pair_slice
    import maj_add_pkg::*;
#(
    parameter bit FIRST = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] a,
    input  logic [1:0] b,
    input  bit_terms_t lo_terms,
    input  logic       carry_in,
    output logic [1:0] sum,
    output logic       carry_out
);
    logic mid_carry;
    logic inner_gen;
    logic inner_prop;

    // Odd-position carry, needed only for the upper sum bit.
    assign mid_carry = maj3(a[0], b[0], carry_in);
    assign inner_gen = maj3(a[1], b[1], lo_terms.gen);

    if (FIRST) begin : g_first
        // Carry-in is tied low, so the OR term of bit 0 drops out.
        assign inner_prop = 1'b0;
        assign carry_out  = inner_gen;
    end else begin : g_inner
        assign inner_prop = maj3(a[1], b[1], lo_terms.prop);
        assign carry_out  = maj3(inner_gen, inner_prop, carry_in);
    end

    maj_sum_cell sum_lo_i (.bit_a(a[0]), .bit_b(b[0]), .carry_in(carry_in),  .sum_bit(sum[0]));
    maj_sum_cell sum_hi_i (.bit_a(a[1]), .bit_b(b[1]), .carry_in(mid_carry), .sum_bit(sum[1]));

    // R2: two-position carry agrees with the lookahead expression
    p_lookahead_r2: assert property (@(posedge clk) disable iff (rst)
        carry_out == ((a[1] & b[1])
                    | ((a[1] | b[1]) & lo_terms.gen)
                    | ((a[1] | b[1]) & lo_terms.prop & carry_in)));

    // R1: the lower bit pair behaves as a full adder
    p_low_pair_r1: assert property (@(posedge clk) disable iff (rst)
        {mid_carry, sum[0]} == 2'(a[0]) + 2'(b[0]) + 2'(carry_in));

    // R1: the least significant slice sees no carry-in
    p_first_cin_r1: assert property (@(posedge clk) disable iff (rst)
        FIRST |-> (carry_in == 1'b0));
endmodule

// File: rtl/maj_pair_adder.sv
module maj_pair_adder
    import maj_add_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);
    localparam int PAIRS = WIDTH / 2;

    if ((WIDTH % 2) != 0 || WIDTH < 2) begin : g_bad_width
        $error("maj_pair_adder: WIDTH must be even and at least 2");
    end

    bit_terms_t [WIDTH-1:0] terms;
    logic [PAIRS:0]         pair_carry;
    logic [WIDTH-1:0]       sum_comb;

    maj_bit_terms #(.WIDTH(WIDTH)) terms_i (
        .op_a  (op_a),
        .op_b  (op_b),
        .terms (terms)
    );

    assign pair_carry[0] = 1'b0;

    for (genvar k = 0; k < PAIRS; k++) begin : g_slice
        maj_pair_slice #(.FIRST(k == 0)) slice_i (
            .clk       (clk),
            .rst       (rst),
            .a         (op_a[2*k+1 -: 2]),
            .b         (op_b[2*k+1 -: 2]),
            .lo_terms  (terms[2*k]),
            .carry_in  (pair_carry[k]),
            .sum       (sum_comb[2*k+1 -: 2]),
            .carry_out (pair_carry[k+1])
        );
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sum       <= '0;
                carry_out <= 1'b0;
            end else begin
                sum       <= sum_comb;
                carry_out <= pair_carry[PAIRS];
            end
        end

        // R7: registered result is the previous edge's operand sum
        p_reg_latency_r7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ({carry_out, sum} == ({1'b0, $past(op_a)} + {1'b0, $past(op_b)})));

        // R8: reset leaves the outputs cleared
        p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
            $fell(rst) |-> (sum == '0 && carry_out == 1'b0));
    end else begin : g_comb
        assign sum       = sum_comb;
        assign carry_out = pair_carry[PAIRS];

        // R1, R6: combinational result equals the arithmetic sum
        p_sum_exact_r1: assert property (@(posedge clk) disable iff (rst)
            {carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b}));
    end
endmodule

// File: tb/maj_pair_adder_tb_top.sv
module maj_pair_adder_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    int   total = 0;
    int   bad   = 0;
    int   cycles = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    logic [7:0]  a8,  b8,  s8;   logic c8;
    logic [15:0] a16, b16, s16;  logic c16;
    logic [31:0] a32, b32, s32;  logic c32;
    logic [63:0] a64, b64, s64;  logic c64;
    logic [15:0] ra,  rb,  rs;   logic rc;

    maj_pair_adder #(.WIDTH(8))  dut_w8_i  (.clk(clk), .rst(rst), .op_a(a8),  .op_b(b8),  .sum(s8),  .carry_out(c8));
    maj_pair_adder #(.WIDTH(16)) dut_w16_i (.clk(clk), .rst(rst), .op_a(a16), .op_b(b16), .sum(s16), .carry_out(c16));
    maj_pair_adder #(.WIDTH(32)) dut_w32_i (.clk(clk), .rst(rst), .op_a(a32), .op_b(b32), .sum(s32), .carry_out(c32));
    maj_pair_adder #(.WIDTH(64)) dut_w64_i (.clk(clk), .rst(rst), .op_a(a64), .op_b(b64), .sum(s64), .carry_out(c64));
    maj_pair_adder #(.WIDTH(16), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .op_a(ra), .op_b(rb), .sum(rs), .carry_out(rc));

    task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [64:0] ref_add(input logic [63:0] x, input logic [63:0] y, input int w);
        logic [63:0] m;
        m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        return {1'b0, x & m} + {1'b0, y & m};
    endfunction

    task automatic drive_all(input string tag, input logic [63:0] x, input logic [63:0] y);
        a8 = x[7:0];   b8 = y[7:0];
        a16 = x[15:0]; b16 = y[15:0];
        a32 = x[31:0]; b32 = y[31:0];
        a64 = x;       b64 = y;
        #1;
        check({tag, " w8"},  {56'd0, c8,  s8},  ref_add(x, y, 8));
        check({tag, " w16"}, {48'd0, c16, s16}, ref_add(x, y, 16));
        check({tag, " w32"}, {32'd0, c32, s32}, ref_add(x, y, 32));
        check({tag, " w64"}, {c64, s64},        ref_add(x, y, 64));
    endtask

    task automatic t_exhaustive8();
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                a8 = 8'(i); b8 = 8'(j);
                #1;
                check("R1 R6 exhaustive w8", {56'd0, c8, s8}, 65'(i + j));
            end
        end
    endtask

    task automatic t_corners();
        drive_all("R4 zeros", 64'd0, 64'd0);
        drive_all("R4 alternating", {16{4'h5}}, {16{4'hA}});
        drive_all("R3 ones plus one", '1, 64'd1);
        drive_all("R3 ones plus ones", '1, '1);
        drive_all("R2 msb generate", {16{4'hA}}, {16{4'hA}});
        drive_all("R2 msb pair only", 64'h8000_8000_8000_8080, 64'h8000_8000_8000_8080);
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            drive_all("R5 R1 random", {$urandom(), $urandom()}, {$urandom(), $urandom()});
        end
    endtask

    task automatic t_registered();
        ra = 16'hFFFF; rb = 16'h0001; rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 reset clears", {48'd0, rc, rs}, 65'd0);
        rst = 1'b0;
        ra = 16'h1234; rb = 16'h4321;
        #1;
        check("R7 no change before edge", {48'd0, rc, rs}, 65'd0);
        @(negedge clk);
        check("R7 one edge latency", {48'd0, rc, rs}, 65'h5555);
        ra = 16'hFFFF; rb = 16'h0001;
        #1;
        check("R7 held between edges", {48'd0, rc, rs}, 65'h5555);
        @(negedge clk);
        check("R7 carry registered", {48'd0, rc, rs}, 65'h10000);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run reset", {48'd0, rc, rs}, 65'd0);
        rst = 1'b0;
        ra = 16'hAAAA; rb = 16'hAAAA;
        @(negedge clk);
        check("R7 after reset", {48'd0, rc, rs}, 65'h15554);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        a8 = '0; b8 = '0; a16 = '0; b16 = '0; a32 = '0; b32 = '0; a64 = '0; b64 = '0;
        ra = '0; rb = '0;
        repeat (2) @(negedge clk);
        t_registered();
        t_corners();
        t_random();
        t_exhaustive8();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule